// File: doc/BRIEF.md
# CAN Node Error Counters with Warning Interrupt

This block keeps the transmit and receive error counts of a CAN controller node. The protocol engine sends it one-cycle event strobes once it has sorted each frame's outcome: a transmit error, a transmit acknowledge error, a receive error, a clean transmit or a clean receive. Each error raises its counter by eight. Each clean transfer lowers it by one. From the two counts the block derives a warning status per counter, an error-passive indication and a sticky transmit-warning interrupt.

Software can overwrite either counter, but only after the module has reached freeze mode. A two-state machine (`ST_RUN`, `ST_FROZEN`) runs the freeze handshake. In `ST_RUN` the machine moves to `ST_FROZEN` on the edge that samples freeze-enable and halt both high (transition *enter*). In `ST_FROZEN` it moves back to `ST_RUN` on the edge that samples halt or freeze-enable low (transition *leave*). The acknowledge output is high exactly in `ST_FROZEN`. Each counter applies one operation per cycle, chosen in priority order: `OP_LOAD` (a gated software write), then `OP_ERR`, then `OP_ACK` (a capped acknowledge error), then `OP_OK`, otherwise `OP_HOLD`.

Top module: `can_err_tracker`

## Requirements
- R1: A tx_err or rx_err strobe raises its counter by 8 on the next edge and saturates at 255. If an error strobe and a success strobe reach the same counter in one cycle, the error wins.
- R2: A tx_ok or rx_ok strobe lowers its counter by 1 on the next edge. A counter at 0 stays at 0.
- R3: tx_warn is high exactly when tx_cnt is 96 or more, and rx_warn is high exactly when rx_cnt is 96 or more. Both follow the count with no delay.
- R4: While warn_irq_en is 1, tx_warn_irq sets on the edge after tx_warn goes from 0 to 1. If tx_warn stays high it does not set the flag again. A new interrupt needs tx_cnt to fall below 96 and then climb back. A 0-to-1 change of tx_warn while warn_irq_en is 0 never sets the flag, not even after the enable returns.
- R5: tx_warn_irq stays set until a cycle in which warn_irq_clr is 1 clears it. If a new set and a clear happen in the same cycle, the set wins.
- R6: frz_ack rises on the edge that samples frz_en and halt_req both at 1. A halt_req without frz_en does not freeze. frz_ack falls on the edge that samples halt_req at 0.
- R7: tx_cnt_wr and rx_cnt_wr load cnt_wdata into their counter on the next edge, but only while frz_ack is 1. A write at any other time leaves the counter unchanged.
- R8: A tx_ack_err strobe raises tx_cnt by 8 but never above 128. Once tx_cnt is 128 or more, the strobe has no effect.
- R9: err_passive is high exactly when tx_cnt or rx_cnt is 128 or more.
- R10: After reset both counters are 0, and frz_ack, tx_warn_irq, both warning flags and err_passive are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err | input | 1 | Transmit error detected |
| tx_ack_err | input | 1 | Transmit acknowledge error (no receiver acknowledged) |
| tx_ok | input | 1 | Frame transmitted without error |
| rx_err | input | 1 | Receive error detected |
| rx_ok | input | 1 | Frame received without error |
| frz_en | input | 1 | Freeze enable |
| halt_req | input | 1 | Halt request; enters freeze when frz_en is set |
| frz_ack | output | 1 | Freeze reached |
| tx_cnt_wr | input | 1 | Software write strobe for the transmit counter |
| rx_cnt_wr | input | 1 | Software write strobe for the receive counter |
| cnt_wdata | input | 8 | Value to load on a software write |
| warn_irq_en | input | 1 | Enables setting of the warning interrupt |
| warn_irq_clr | input | 1 | Write-1-to-clear strobe for the interrupt |
| tx_cnt | output | 8 | Transmit error count |
| rx_cnt | output | 8 | Receive error count |
| tx_warn | output | 1 | Transmit count at or above 96 |
| rx_warn | output | 1 | Receive count at or above 96 |
| err_passive | output | 1 | Either count at or above 128 |
| tx_warn_irq | output | 1 | Sticky transmit-warning interrupt flag |

## Verification
The bench moves tx_cnt across 96 in both directions. A design that fires on the level of the warning, rather than its edge, would set the flag again right after a clear while the count stays high. A design that does not re-arm would stay silent on the second crossing. The bench also raises the warning while the interrupt is disabled and then enables it: a design that remembered the missed edge would fire late. Writes are tried both outside and inside freeze, and a halt is tried without freeze enable; a missing gate would let the counter change. The bench also drives the counters into both saturation limits (255 for errors, 128 for acknowledge errors) and down to the floor at 0. It makes a set and a clear of the interrupt collide in one cycle, and sends an error and a success to the same counter in one cycle.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FROZEN = 1'b1
    } frz_state_t;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_LOAD = 3'd1,
        OP_ERR  = 3'd2,
        OP_ACK  = 3'd3,
        OP_OK   = 3'd4
    } cnt_op_t;
endpackage

// File: rtl/can_err_freeze_fsm.sv
module can_err_freeze_fsm
    import can_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frz_en_i,
    input  logic halt_i,
    output logic ack_o
);
    frz_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (frz_en_i && halt_i)    state_d = ST_FROZEN;
            ST_FROZEN: if (!frz_en_i || !halt_i)  state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_o = (state_q == ST_FROZEN);
    end

    assert_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && frz_en_i && halt_i) |=> ack_o);
    assert_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !halt_i) |=> !ack_o);
    assert_need_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && !frz_en_i) |=> !ack_o);
endmodule

// File: rtl/can_err_counter.sv
module can_err_counter
    import can_err_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ERR_STEP  = 8,
    parameter int ACK_CAP   = 128,
    parameter bit ACK_USED  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             err_i,
    input  logic             ack_err_i,
    input  logic             ok_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    cnt_op_t          op;
    logic [CNT_W:0]   cnt_up;
    logic [CNT_W-1:0] cnt_q, cnt_d, err_val, ack_val;

    always_comb begin
        if (load_i)                    op = OP_LOAD;
        else if (err_i)                op = OP_ERR;
        else if (ack_err_i && ACK_USED) op = OP_ACK;
        else if (ok_i)                 op = OP_OK;
        else                           op = OP_HOLD;
    end

    always_comb begin
        cnt_up  = {1'b0, cnt_q} + (CNT_W+1)'(ERR_STEP);
        err_val = (cnt_up > (CNT_W+1)'(CNT_MAX)) ? CNT_W'(CNT_MAX) : cnt_up[CNT_W-1:0];
        if (cnt_q >= CNT_W'(ACK_CAP))
            ack_val = cnt_q;
        else if (cnt_up > (CNT_W+1)'(ACK_CAP))
            ack_val = CNT_W'(ACK_CAP);
        else
            ack_val = cnt_up[CNT_W-1:0];
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            OP_LOAD: cnt_d = load_val_i;
            OP_ERR:  cnt_d = err_val;
            OP_ACK:  cnt_d = ack_val;
            OP_OK:   cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            OP_HOLD: cnt_d = cnt_q;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_err_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !load_i) |=>
        (int'(cnt_o) == ((int'($past(cnt_o)) + ERR_STEP > CNT_MAX) ? CNT_MAX
                                                                  : int'($past(cnt_o)) + ERR_STEP)));
    assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_i && !err_i && !ack_err_i && !load_i && cnt_o == '0) |=> (cnt_o == '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !err_i && !ack_err_i && !ok_i) |=> $stable(cnt_o));
    assert_ack_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ACK_USED && ack_err_i && !err_i && !load_i && cnt_o >= CNT_W'(ACK_CAP)) |=> $stable(cnt_o));
endmodule

// File: rtl/can_err_warn.sv
module can_err_warn #(
    parameter int CNT_W       = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    output logic             tx_warn_o,
    output logic             rx_warn_o,
    output logic             passive_o,
    output logic             irq_o
);
    logic tx_warn_q, irq_q, irq_set;

    always_comb begin
        tx_warn_o = (tx_cnt_i >= CNT_W'(WARN_LVL));
        rx_warn_o = (rx_cnt_i >= CNT_W'(WARN_LVL));
        passive_o = (tx_cnt_i >= CNT_W'(PASSIVE_LVL)) || (rx_cnt_i >= CNT_W'(PASSIVE_LVL));
        irq_set   = irq_en_i && tx_warn_o && !tx_warn_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_warn_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            tx_warn_q <= tx_warn_o;
            if (irq_set)        irq_q <= 1'b1;
            else if (irq_clr_i) irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !irq_en_i) |=> !irq_o);
    assert_irq_needs_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !tx_warn_o) |=> !irq_o);
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);
endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker #(
    parameter int CNT_W       = 8,
    parameter int ERR_STEP    = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128,
    parameter int ACK_CAP     = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             tx_ack_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             frz_en,
    input  logic             halt_req,
    output logic             frz_ack,
    input  logic             tx_cnt_wr,
    input  logic             rx_cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             warn_irq_en,
    input  logic             warn_irq_clr,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt,
    output logic             tx_warn,
    output logic             rx_warn,
    output logic             err_passive,
    output logic             tx_warn_irq
);
    logic tx_load, rx_load;

    can_err_freeze_fsm u_frz (
        .clk      (clk),
        .rst_n    (rst_n),
        .frz_en_i (frz_en),
        .halt_i   (halt_req),
        .ack_o    (frz_ack)
    );

    assign tx_load = tx_cnt_wr && frz_ack;
    assign rx_load = rx_cnt_wr && frz_ack;

    can_err_counter #(.CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .ACK_CAP(ACK_CAP), .ACK_USED(1'b1)) u_tx_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tx_load),
        .load_val_i (cnt_wdata),
        .err_i      (tx_err),
        .ack_err_i  (tx_ack_err),
        .ok_i       (tx_ok),
        .cnt_o      (tx_cnt)
    );

    can_err_counter #(.CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .ACK_CAP(ACK_CAP), .ACK_USED(1'b0)) u_rx_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rx_load),
        .load_val_i (cnt_wdata),
        .err_i      (rx_err),
        .ack_err_i  (1'b0),
        .ok_i       (rx_ok),
        .cnt_o      (rx_cnt)
    );

    can_err_warn #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)) u_warn (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_cnt_i  (tx_cnt),
        .rx_cnt_i  (rx_cnt),
        .irq_en_i  (warn_irq_en),
        .irq_clr_i (warn_irq_clr),
        .tx_warn_o (tx_warn),
        .rx_warn_o (rx_warn),
        .passive_o (err_passive),
        .irq_o     (tx_warn_irq)
    );

    assert_ignore_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_ack && !tx_err && !tx_ack_err && !tx_ok) |=> $stable(tx_cnt));
    assert_ignore_rx_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_ack && !rx_err && !rx_ok) |=> $stable(rx_cnt));
endmodule

// File: tb/can_err_tracker_bench.sv
module can_err_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 0, tx_ack_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0;
    logic       frz_en = 0, halt_req = 0, tx_cnt_wr = 0, rx_cnt_wr = 0;
    logic [7:0] cnt_wdata = '0;
    logic       warn_irq_en = 0, warn_irq_clr = 0;
    logic       frz_ack, tx_warn, rx_warn, err_passive, tx_warn_irq;
    logic [7:0] tx_cnt, rx_cnt;

    always #10 clk = ~clk;

    can_err_tracker u_can_err_tracker (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ack_err(tx_ack_err), .tx_ok(tx_ok),
        .rx_err(rx_err), .rx_ok(rx_ok), .frz_en(frz_en), .halt_req(halt_req), .frz_ack(frz_ack),
        .tx_cnt_wr(tx_cnt_wr), .rx_cnt_wr(rx_cnt_wr), .cnt_wdata(cnt_wdata),
        .warn_irq_en(warn_irq_en), .warn_irq_clr(warn_irq_clr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_warn(tx_warn), .rx_warn(rx_warn), .err_passive(err_passive), .tx_warn_irq(tx_warn_irq)
    );

    typedef struct {
        string tag;
        int    tx, rx;
        bit    txw, rxw, ep, irq, ack;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;

    // reference model state
    int m_tx = 0, m_rx = 0;
    bit m_warnq = 0, m_irq = 0, m_ack = 0;

    task automatic tick(input string tag);
        exp_t e;
        int   ntx, nrx;
        bit   wprev;
        @(posedge clk);
        ntx = m_tx;
        if (tx_cnt_wr && m_ack)  ntx = cnt_wdata;
        else if (tx_err)         ntx = (m_tx + 8 > 255) ? 255 : m_tx + 8;
        else if (tx_ack_err)     ntx = (m_tx >= 128) ? m_tx : ((m_tx + 8 > 128) ? 128 : m_tx + 8);
        else if (tx_ok)          ntx = (m_tx == 0) ? 0 : m_tx - 1;
        nrx = m_rx;
        if (rx_cnt_wr && m_ack)  nrx = cnt_wdata;
        else if (rx_err)         nrx = (m_rx + 8 > 255) ? 255 : m_rx + 8;
        else if (rx_ok)          nrx = (m_rx == 0) ? 0 : m_rx - 1;
        wprev = (m_tx >= 96);
        if (warn_irq_en && wprev && !m_warnq) m_irq = 1;
        else if (warn_irq_clr)                m_irq = 0;
        m_warnq = wprev;
        m_ack   = m_ack ? (frz_en && halt_req) : (frz_en && halt_req);
        m_tx = ntx;
        m_rx = nrx;
        e.tag = tag; e.tx = m_tx; e.rx = m_rx;
        e.txw = (m_tx >= 96); e.rxw = (m_rx >= 96);
        e.ep  = (m_tx >= 128) || (m_rx >= 128);
        e.irq = m_irq; e.ack = m_ack;
        #1;
        q.push_back(e);
        tx_err = 0; tx_ack_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
        tx_cnt_wr = 0; rx_cnt_wr = 0; warn_irq_clr = 0;
    endtask

    // monitor: compare outputs against queued expectations at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = q.pop_front();
            bad = 0;
            n_run++;
            if (int'(tx_cnt) != e.tx) begin bad = 1; $display("FAIL %s tx_cnt actual %0d expected %0d", e.tag, tx_cnt, e.tx); end
            if (int'(rx_cnt) != e.rx) begin bad = 1; $display("FAIL %s rx_cnt actual %0d expected %0d", e.tag, rx_cnt, e.rx); end
            if (tx_warn != e.txw)     begin bad = 1; $display("FAIL %s tx_warn actual %0b expected %0b", e.tag, tx_warn, e.txw); end
            if (rx_warn != e.rxw)     begin bad = 1; $display("FAIL %s rx_warn actual %0b expected %0b", e.tag, rx_warn, e.rxw); end
            if (err_passive != e.ep)  begin bad = 1; $display("FAIL %s err_passive actual %0b expected %0b", e.tag, err_passive, e.ep); end
            if (tx_warn_irq != e.irq) begin bad = 1; $display("FAIL %s tx_warn_irq actual %0b expected %0b", e.tag, tx_warn_irq, e.irq); end
            if (frz_ack != e.ack)     begin bad = 1; $display("FAIL %s frz_ack actual %0b expected %0b", e.tag, frz_ack, e.ack); end
            if (bad) n_fail++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        n_run++;
        if (tx_cnt !== 8'd0 || rx_cnt !== 8'd0 || frz_ack !== 1'b0 || tx_warn_irq !== 1'b0 ||
            tx_warn !== 1'b0 || rx_warn !== 1'b0 || err_passive !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset actual tx=%0d rx=%0d ack=%0b irq=%0b expected all zero",
                     tx_cnt, rx_cnt, frz_ack, tx_warn_irq);
        end
        rst_n = 1'b1;
        warn_irq_en = 1;

        // R1 R3: climb to 96, interrupt on the following edge (R4)
        for (int i = 0; i < 12; i++) begin tx_err = 1; tick("R1 R3 tx error climb"); end
        tick("R4 irq after rising warn");
        for (int i = 0; i < 2; i++) begin tx_err = 1; tick("R4 level stays high"); end
        warn_irq_clr = 1; tick("R5 clear");
        for (int i = 0; i < 3; i++) tick("R4 no re-set on level");
        // R2: drop below 96, then re-arm
        for (int i = 0; i < 20; i++) begin tx_ok = 1; tick("R2 success decrement"); end
        tx_err = 1; tick("R4 re-cross");
        tick("R4 re-fire");
        // R5: set and clear collide
        warn_irq_clr = 1; tick("R5 clear");
        for (int i = 0; i < 5; i++) begin tx_ok = 1; tick("R2 down to 95"); end
        tx_err = 1; tick("R4 cross again");
        warn_irq_clr = 1; tick("R5 set wins over clear");
        tick("R5 sticky");
        warn_irq_clr = 1; tick("R5 clear");
        // R4: edge while disabled is not remembered
        warn_irq_en = 0;
        for (int i = 0; i < 8; i++) begin tx_ok = 1; tick("R2 down"); end
        tx_err = 1; tick("R4 cross while disabled");
        tick("R4 disabled no irq");
        warn_irq_en = 1;
        tick("R4 enable after edge");
        tick("R4 still no irq");
        // R1: error beats success in one cycle
        tx_err = 1; tx_ok = 1; tick("R1 error wins over ok");
        // R1 R9: receive saturation
        for (int i = 0; i < 33; i++) begin rx_err = 1; tick("R1 R9 rx saturate"); end
        for (int i = 0; i < 2; i++) begin rx_ok = 1; tick("R2 rx decrement"); end
        // R7: write outside freeze
        cnt_wdata = 8'd5; tx_cnt_wr = 1; rx_cnt_wr = 1; tick("R7 write ignored");
        tick("R7 hold");
        // R6: halt without enable
        halt_req = 1; tick("R6 halt without enable");
        tick("R6 still running");
        frz_en = 1; tick("R6 freeze entered");
        cnt_wdata = 8'd0; tx_cnt_wr = 1; rx_cnt_wr = 1; tick("R7 write in freeze");
        rx_ok = 1; tick("R2 floor at zero");
        cnt_wdata = 8'd100; tx_cnt_wr = 1; tick("R7 load value");
        cnt_wdata = 8'd0; tx_cnt_wr = 1; tick("R7 reload zero");
        halt_req = 0; tick("R6 freeze left");
        frz_en = 0; tick("R6 running");
        // R8: acknowledge errors cap at 128
        for (int i = 0; i < 20; i++) begin tx_ack_err = 1; tick("R8 R9 ack error cap"); end
        warn_irq_clr = 1; tick("R5 clear");
        tx_err = 1; tick("R1 error above cap");
        tx_ack_err = 1; tick("R8 no effect above cap");
        tick("R9 idle");
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule